// File: doc/BRIEF.md
# Region-Selectable Audio Frame Sequencer

This block is the timing backbone of a console audio unit. It counts CPU cycles and produces two strobes at fixed points in each frame. The quarter strobe drives the envelope and linear-counter units, and the half strobe drives the length and sweep units. In 4-step mode it can also raise a frame interrupt. A 2-bit region input selects one of two step tables: PAL, or NTSC for every other code.

Software controls the block with a single register write. That write carries the step mode and an interrupt-inhibit bit. After the write, the cycle counter restarts following a short delay whose length depends on CPU-cycle parity. A read of the status register clears the interrupt flag. The consumers of the strobes lie outside this block.

Top module: `apu_frame_seq`

## Requirements
- R1: After reset all outputs are 0, the mode is 4-step, inhibit is clear, and the counter starts at 0. The first quarter strobe therefore appears on the 7458th enabled cycle.
- R2: NTSC 4-step mode puts quarter strobes at counter values 7457, 14913, 22371 and 29829, and half strobes at 14913 and 29829. The counter runs from 0 to 29830 and then wraps to 0.
- R3: NTSC 5-step mode puts quarter strobes at 7457, 14913, 22371 and 37281, and half strobes at 14913 and 37281. The counter runs from 0 to 37282.
- R4: PAL 4-step mode puts quarter strobes at 8313, 16627, 24939 and 33253, and half strobes at 16627 and 33253. The counter runs from 0 to 33254.
- R5: PAL 5-step mode puts quarter strobes at 8313, 16627, 24939 and 41565, and half strobes at 16627 and 41565. The counter runs from 0 to 41566.
- R6: `region_i` = 2'b01 selects the PAL table. The codes 2'b00, 2'b10 and 2'b11 select the NTSC table. The table is chosen afresh on every cycle.
- R7: The counter advances only on cycles where `cpu_en_i` is high. Step strobes appear only on enabled cycles.
- R8: In 4-step mode the interrupt flag is set on every enabled cycle whose count lies in the final window, unless inhibit is set. The window is 29828–29830 for NTSC and 33252–33254 for PAL. The flag shows on the next clock. 5-step mode never sets the flag.
- R9: A register write with inhibit = 1 clears the flag on the next clock. A status read clears the flag unless a set occurs in the same cycle, in which case the set wins.
- R10: A register write reloads the counter to 0 on the 3rd enabled cycle after the write if the parity flop was even at the write, and on the 4th if it was odd. The parity flop toggles on every enabled cycle and is even after reset. The mode and inhibit bits take effect in the write cycle itself.
- R11: A write selecting 5-step mode drives `qtr_o` and `half_o` high in the write cycle, whether or not the cycle is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_en_i | input | 1 | One-clock CPU-cycle enable |
| wr_i | input | 1 | Register write strobe |
| wr_mode5_i | input | 1 | Write data: 1 = 5-step, 0 = 4-step |
| wr_irq_inh_i | input | 1 | Write data: interrupt inhibit |
| region_i | input | 2 | Region code; 2'b01 = PAL, any other code = NTSC |
| status_rd_i | input | 1 | Status read strobe; clears the flag |
| qtr_o | output | 1 | Quarter-frame strobe |
| half_o | output | 1 | Half-frame strobe |
| irq_flag_o | output | 1 | Frame interrupt flag |

## Verification
The in-line assertions check the following on every clock:
- a half strobe always comes with a quarter strobe;
- the counter stays still on disabled cycles;
- the counter reloads when the pending delay expires;
- the flag rises only out of an enabled, uninhibited 4-step window cycle;
- an inhibit write clears the flag.

Some properties can be shown only by the bench's scenarios:
- the step positions of all four tables;
- the frame lengths;
- the 3-versus-4-cycle restart at each parity;
- the treatment of the non-PAL region codes.

The bench compares a behavioural model against these on every clock.

// File: rtl/apu_seq_pkg.sv
package apu_seq_pkg;
  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    RGN_NTSC  = 2'b00,
    RGN_PAL   = 2'b01,
    RGN_ALT_A = 2'b10,
    RGN_ALT_B = 2'b11
  } region_e;

  // step positions; lo/hi bound the final window of each mode
  typedef struct packed {
    cnt_t s1;
    cnt_t s2;
    cnt_t s3;
    cnt_t lo4;
    cnt_t hi4;
    cnt_t lo5;
    cnt_t hi5;
  } step_tab_t;

  localparam step_tab_t TAB_NTSC = '{
    s1: cnt_t'(7457),  s2: cnt_t'(14913), s3: cnt_t'(22371),
    lo4: cnt_t'(29828), hi4: cnt_t'(29830),
    lo5: cnt_t'(37281), hi5: cnt_t'(37282)};

  localparam step_tab_t TAB_PAL = '{
    s1: cnt_t'(8313),  s2: cnt_t'(16627), s3: cnt_t'(24939),
    lo4: cnt_t'(33252), hi4: cnt_t'(33254),
    lo5: cnt_t'(41565), hi5: cnt_t'(41566)};
endpackage

// File: rtl/apu_seq_decode.sv
module apu_seq_decode
  import apu_seq_pkg::*;
(
  input  cnt_t cnt_i,
  input  logic mode5_i,
  input  logic pal_i,
  output logic step_q_o,
  output logic step_h_o,
  output logic irq_win_o,
  output logic at_end_o
);
  step_tab_t tab;
  cnt_t lo, hi;

  always_comb begin
    tab       = pal_i ? TAB_PAL : TAB_NTSC;
    lo        = mode5_i ? tab.lo5 : tab.lo4;
    hi        = mode5_i ? tab.hi5 : tab.hi4;
    // final step fires one cycle before the window ends
    step_h_o  = (cnt_i == tab.s2) || (cnt_i == hi - cnt_t'(1));
    step_q_o  = step_h_o || (cnt_i == tab.s1) || (cnt_i == tab.s3);
    irq_win_o = !mode5_i && (cnt_i >= lo) && (cnt_i <= hi);
    at_end_o  = cnt_i >= hi;
  end
endmodule

// File: rtl/apu_seq_timer.sv
module apu_seq_timer
  import apu_seq_pkg::*;
#(
  parameter int DLY_EVEN = 3,
  parameter int DLY_ODD  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wr_i,
  input  logic at_end_i,
  output cnt_t cnt_o
);
  localparam int DLY_MAX = (DLY_ODD > DLY_EVEN) ? DLY_ODD : DLY_EVEN;
  localparam int PW      = $clog2(DLY_MAX + 1);

  logic          odd_q;
  logic [PW-1:0] pend_q;
  logic          restart;

  assign restart = en_i && !wr_i && (pend_q == PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q  <= 1'b0;
      pend_q <= '0;
      cnt_o  <= '0;
    end else begin
      if (en_i) odd_q <= ~odd_q;
      if (wr_i)                        pend_q <= odd_q ? PW'(DLY_ODD) : PW'(DLY_EVEN);
      else if (en_i && pend_q != '0)   pend_q <= pend_q - PW'(1);
      if (en_i) begin
        if (restart || at_end_i) cnt_o <= '0;
        else                     cnt_o <= cnt_o + cnt_t'(1);
      end
    end
  end

  // R7
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o));
  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> cnt_o == '0);
  // R10
  pend_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PW'(DLY_MAX));
endmodule

// File: rtl/apu_frame_seq.sv
module apu_frame_seq
  import apu_seq_pkg::*;
#(
  parameter int DLY_EVEN = 3,
  parameter int DLY_ODD  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cpu_en_i,
  input  logic       wr_i,
  input  logic       wr_mode5_i,
  input  logic       wr_irq_inh_i,
  input  logic [1:0] region_i,
  input  logic       status_rd_i,
  output logic       qtr_o,
  output logic       half_o,
  output logic       irq_flag_o
);
  logic mode5_q, inh_q, mode5_eff, inh_eff, pal;
  logic step_q, step_h, irq_win, at_end, irq_set, irq_clr;
  cnt_t cnt;

  // new mode/inhibit act in the write cycle
  assign mode5_eff = wr_i ? wr_mode5_i   : mode5_q;
  assign inh_eff   = wr_i ? wr_irq_inh_i : inh_q;
  assign pal       = region_e'(region_i) == RGN_PAL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode5_q <= 1'b0;
      inh_q   <= 1'b0;
    end else if (wr_i) begin
      mode5_q <= wr_mode5_i;
      inh_q   <= wr_irq_inh_i;
    end
  end

  apu_seq_decode u_dec (
    .cnt_i    (cnt),
    .mode5_i  (mode5_eff),
    .pal_i    (pal),
    .step_q_o (step_q),
    .step_h_o (step_h),
    .irq_win_o(irq_win),
    .at_end_o (at_end)
  );

  apu_seq_timer #(.DLY_EVEN(DLY_EVEN), .DLY_ODD(DLY_ODD)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cpu_en_i),
    .wr_i    (wr_i),
    .at_end_i(at_end),
    .cnt_o   (cnt)
  );

  assign qtr_o  = (cpu_en_i && step_q) || (wr_i && wr_mode5_i);
  assign half_o = (cpu_en_i && step_h) || (wr_i && wr_mode5_i);

  assign irq_set = cpu_en_i && irq_win && !inh_eff;
  assign irq_clr = status_rd_i || (wr_i && wr_irq_inh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_flag_o <= 1'b0;
    else if (irq_set) irq_flag_o <= 1'b1;
    else if (irq_clr) irq_flag_o <= 1'b0;
  end

  // R2
  half_in_qtr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |-> qtr_o);
  // R8
  irq_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_flag_o) |-> $past(cpu_en_i && !mode5_eff && !inh_eff));
  // R9
  inh_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_irq_inh_i) |=> !irq_flag_o);
  // R9
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !cpu_en_i) |=> !irq_flag_o);
endmodule

// File: tb/apu_frame_seq_test.sv
module apu_frame_seq_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cpu_en = 0, wr = 0, wr_m5 = 0, wr_ih = 0, rd = 0;
  logic [1:0] region = 2'b00;
  logic qtr, half, irq;

  apu_frame_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_en_i(cpu_en), .wr_i(wr),
    .wr_mode5_i(wr_m5), .wr_irq_inh_i(wr_ih), .region_i(region),
    .status_rd_i(rd), .qtr_o(qtr), .half_o(half), .irq_flag_o(irq));

  int checks = 0, fails = 0;
  string cur_req = "R2";
  bit last_q, last_h, done = 0;
  int nq, nh;
  int m_cnt = 0, m_pend = 0;
  bit m_m5 = 0, m_inh = 0, m_odd = 0, m_flag = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit w, input bit m5, input bit ih,
                      input logic [1:0] rg, input bit r);
    bit pal, me, ie, eq, eh, set;
    int s1, s2, s3, lo, hi;
    @(negedge clk);
    cpu_en = en; wr = w; wr_m5 = m5; wr_ih = ih; region = rg; rd = r;
    #2;
    pal = (rg == 2'b01);
    s1 = pal ? 8313 : 7457; s2 = pal ? 16627 : 14913; s3 = pal ? 24939 : 22371;
    me = w ? m5 : m_m5; ie = w ? ih : m_inh;
    lo = me ? (pal ? 41565 : 37281) : (pal ? 33252 : 29828);
    hi = me ? (pal ? 41566 : 37282) : (pal ? 33254 : 29830);
    eq = (en && (m_cnt == s1 || m_cnt == s2 || m_cnt == s3 || m_cnt == hi - 1)) || (w && m5);
    eh = (en && (m_cnt == s2 || m_cnt == hi - 1)) || (w && m5);
    chk(qtr == eq, {cur_req, " qtr"}, qtr, eq);
    chk(half == eh, {cur_req, " half"}, half, eh);
    chk(irq == m_flag, {cur_req, " R8 irq flag"}, irq, m_flag);
    last_q = qtr; last_h = half;
    nq += int'(qtr); nh += int'(half);
    set = en && !me && m_cnt >= lo && m_cnt <= hi && !ie;
    if (set) m_flag = 1;
    else if (r || (w && ih)) m_flag = 0;
    if (en) m_cnt = (m_pend == 1 && !w) ? 0 : (m_cnt >= hi ? 0 : m_cnt + 1);
    if (w) m_pend = m_odd ? 4 : 3;
    else if (en && m_pend != 0) m_pend--;
    if (en) m_odd = !m_odd;
    if (w) begin m_m5 = m5; m_inh = ih; end
  endtask

  task automatic run(input int n, input logic [1:0] rg);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, rg, 0);
  endtask

  task automatic peek_irq(input bit exp, input string r);
    @(posedge clk); #1;
    chk(irq == exp, r, irq, exp);
  endtask

  // write mode, then run out the restart delay; counts cleared after
  task automatic restart_mode(input bit m5, input bit ih, input logic [1:0] rg);
    int d;
    d = m_odd ? 4 : 3;
    step(1, 1, m5, ih, rg, 0);
    run(d, rg);
    nq = 0; nh = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1
    chk(qtr == 0 && half == 0 && irq == 0, "R1 reset outputs", {qtr, half, irq}, 0);

    // R2 / R6: NTSC table via region 2'b11
    cur_req = "R2"; nq = 0; nh = 0;
    run(7457, 2'b11);
    chk(nq == 0, "R1 no early quarter", nq, 0);
    run(1, 2'b11);
    chk(last_q == 1, "R6 first quarter at 7457 for code 11", last_q, 1);
    run(29831 - 7458, 2'b11);
    chk(nq == 4, "R2 quarters per frame", nq, 4);
    chk(nh == 2, "R2 halves per frame", nh, 2);
    peek_irq(1, "R8 flag after 4-step window");
    cur_req = "R9";
    step(1, 0, 0, 0, 2'b11, 1);
    peek_irq(0, "R9 status read clears");

    // R11 + R3, NTSC via code 2'b10
    cur_req = "R3";
    step(1, 1, 1, 0, 2'b10, 0);
    chk(last_q && last_h, "R11 immediate strobes on 5-step write", {last_q, last_h}, 3);
    run(4, 2'b10);
    nq = 0; nh = 0;
    run(37283, 2'b10);
    chk(nq == 4, "R3 quarters per frame", nq, 4);
    chk(nh == 2, "R3 halves per frame", nh, 2);
    peek_irq(0, "R8 5-step never sets flag");

    // R10 restart at both parities
    cur_req = "R10";
    for (int k = 0; k < 2; k++) begin
      if (k == 1) run(1, 2'b00);
      restart_mode(0, 0, 2'b00);
      run(7457, 2'b00);
      chk(nq == 0, "R10 no quarter before restart offset", nq, 0);
      run(1, 2'b00);
      chk(last_q == 1, "R10 quarter 7457 after restart", last_q, 1);
    end

    // R4 PAL 4-step
    cur_req = "R4";
    restart_mode(0, 0, 2'b01);
    run(33254, 2'b01);
    chk(nq == 4, "R4 quarters per frame", nq, 4);
    chk(nh == 2, "R4 halves per frame", nh, 2);
    peek_irq(1, "R8 PAL window sets flag");
    cur_req = "R9";
    step(1, 1, 0, 1, 2'b01, 0);
    peek_irq(0, "R9 inhibit write clears");

    // R5 PAL 5-step
    cur_req = "R5";
    restart_mode(1, 0, 2'b01);
    run(41567, 2'b01);
    chk(nq == 4, "R5 quarters per frame", nq, 4);
    chk(nh == 2, "R5 halves per frame", nh, 2);

    // R7 gaps hold the counter
    cur_req = "R7";
    restart_mode(0, 0, 2'b00);
    run(7000, 2'b00);
    for (int i = 0; i < 500; i++) step(0, 0, 0, 0, 2'b00, 0);
    run(457, 2'b00);
    chk(nq == 0, "R7 disabled cycles do not count", nq, 0);
    run(1, 2'b00);
    chk(last_q == 1, "R7 quarter after gap", last_q, 1);

    // R10 mixed: random enables, writes, reads, regions
    cur_req = "R10";
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[7:2] == 6'd0, lfsr[8], lfsr[9] & lfsr[10],
           lfsr[12:11], lfsr[15:13] == 3'd0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule